// File: doc/BRIEF.md
# I2C Slave Receiver with Status Codes

This block is the receiving half of an I2C-bus target. It watches the SCL and SDA lines, which it samples on the system clock. It compares each address byte after a start condition with a programmable 7-bit own address. The general call address can also be enabled or disabled. When it is selected for a write, it acknowledges the address and then the data bytes, one byte at a time.

After every bus event the block sets an interrupt flag and pulls its active-low interrupt output low. It also loads an 8-bit status code. Host software reads that code to decide what to do next. After a byte event the block holds SCL low, and it lets the bus go only when the host clears the flag.

The host side has four byte-wide registers. A write to a register takes effect on the next clock edge. A read returns the value one clock after the address is presented. Clearing the acknowledge-enable bit makes the block refuse the next data byte. While that bit stays clear, the device is cut off from the bus, but it still tracks start and stop conditions.

Top module: `i2cs_recv`

## Requirements
- R1: After reset irq_n is 1, scl_oe and sda_oe are 0, the status register reads F8h, and the address and control registers read 00h.
- R2: Register map, selected by reg_addr: 0 is the own address, with the 7-bit address in bits 7:1 and the general-call enable in bit 0. 1 is control: bit 0 interface enable, bit 1 acknowledge enable, bit 2 start request, bit 3 stop request, bit 4 interrupt flag. 2 is status (read only). 3 is the last received data byte (read only). reg_rdata shows the addressed register one clock after reg_addr is set.
- R3: With enable=1, ack-enable=1 and start=stop=0, an address byte equal to the own address with direction bit 0 is acknowledged (SDA low in the ninth clock). At the falling edge of the ninth clock the flag is set, irq_n goes low and the status becomes 60h.
- R4: Any other address byte is not acknowledged and raises no flag. This includes the own address with direction bit 1. The block then ignores the bus until the next start, so a following stop raises nothing.
- R5: Address byte 00h is acknowledged with status D0h when general-call enable is 1, and is not acknowledged when it is 0.
- R6: While addressed with ack-enable=1, each data byte is acknowledged, the status becomes 80h and the data register holds the byte.
- R7: If ack-enable is 0 at the eighth bit of a data byte, that byte is not acknowledged. The status becomes 88h, the data register holds the byte, and the block becomes unaddressed, so a later stop raises no flag.
- R8: While ack-enable is 0, the own address is not acknowledged. Once it is set to 1 again, the next own address is acknowledged.
- R9: A stop or a repeated start while addressed loads A0h and sets the flag without holding SCL. After a repeated start, the following address byte is decoded afresh.
- R10: After a 60h, D0h, 80h or 88h event, scl_oe stays 1 until the host writes control with bit 4 at 0. Writing bit 4 as 1 never sets the flag.
- R11: With interface enable at 0, or with the start or stop request bit at 1, the block acknowledges no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (open drain) |
| sda_oe | output | 1 | Pull SDA low (open drain) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults: two synchroniser stages and 8-bit bytes. This keeps the whole 7-bit address space small enough to sweep, so every address is sent with general call enabled and both the own match and the 00h match are checked against arithmetic expectations. A run of sixteen computed data bytes exercises the data path. Separate transfers cover refusal of data bytes, isolation, repeated start, the read direction and the enable and request bits.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam logic [7:0] ST_OWN_W    = 8'h60;
  localparam logic [7:0] ST_GCALL    = 8'hD0;
  localparam logic [7:0] ST_DAT_ACK  = 8'h80;
  localparam logic [7:0] ST_DAT_NACK = 8'h88;
  localparam logic [7:0] ST_END      = 8'hA0;
  localparam logic [7:0] ST_NONE     = 8'hF8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_AACK9, S_DATA, S_DACK, S_DACK9, S_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_rx_engine.sv
module i2cs_rx_engine import i2cs_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ack_en,
  input  logic              gc_en,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              sda_drive,
  output logic              ev_valid,
  output logic [7:0]        ev_code,
  output logic [BYTE_W-1:0] ev_data,
  output logic              ev_hold
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_q, addressed, scl_p, sda_p;
  logic [7:0]        code_q;

  wire scl_rise = scl_s && !scl_p;
  wire scl_fall = !scl_s && scl_p;
  wire start_ev = scl_s && scl_p && sda_p && !sda_s;
  wire stop_ev  = scl_s && scl_p && !sda_p && sda_s;
  wire [BYTE_W-1:0] nxt = {shreg[BYTE_W-2:0], sda_s};
  wire own_hit = (nxt[BYTE_W-1:1] == own_addr) && !nxt[0] && ack_en;
  wire gc_hit  = (nxt == '0) && gc_en && ack_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cnt <= '0; shreg <= '0; ack_q <= 1'b0;
      addressed <= 1'b0; scl_p <= 1'b1; sda_p <= 1'b1; code_q <= ST_NONE;
      sda_drive <= 1'b0; ev_valid <= 1'b0; ev_code <= ST_NONE;
      ev_data <= '0; ev_hold <= 1'b0;
    end else begin
      scl_p    <= scl_s;
      sda_p    <= sda_s;
      ev_valid <= 1'b0;
      if (!en) begin
        state <= S_IDLE; addressed <= 1'b0; sda_drive <= 1'b0;
      end else if (start_ev || stop_ev) begin
        if (addressed) begin
          ev_valid <= 1'b1; ev_code <= ST_END; ev_hold <= 1'b0;
        end
        addressed <= 1'b0;
        sda_drive <= 1'b0;
        cnt       <= '0;
        state     <= start_ev ? S_ADDR : S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_DATA: if (scl_rise) begin
            shreg <= nxt;
            if (cnt == LAST) begin
              cnt <= '0;
              if (state == S_ADDR) begin
                ack_q  <= own_hit || gc_hit;
                code_q <= own_hit ? ST_OWN_W : ST_GCALL;
                state  <= S_AACK;
              end else begin
                ack_q <= ack_en;
                state <= S_DACK;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_AACK: if (scl_fall) begin
            sda_drive <= ack_q;
            state     <= ack_q ? S_AACK9 : S_SKIP;
          end
          S_DACK: if (scl_fall) begin
            sda_drive <= ack_q;
            state     <= S_DACK9;
          end
          S_AACK9: if (scl_fall) begin
            sda_drive <= 1'b0;
            addressed <= 1'b1;
            ev_valid  <= 1'b1; ev_code <= code_q; ev_hold <= 1'b1;
            state     <= S_DATA;
          end
          S_DACK9: if (scl_fall) begin
            sda_drive <= 1'b0;
            ev_valid  <= 1'b1; ev_hold <= 1'b1; ev_data <= shreg;
            ev_code   <= ack_q ? ST_DAT_ACK : ST_DAT_NACK;
            addressed <= ack_q;
            state     <= ack_q ? S_DATA : S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: with acknowledge disabled the address decision is a refusal
  a_r8_no_ack_when_off: assert property (@(posedge clk) disable iff (rst)
    (en && !start_ev && !stop_ev && state == S_ADDR && scl_rise && cnt == LAST && !ack_en)
    |=> !ack_q);

  // R5: general call refused while disabled
  a_r5_gc_off: assert property (@(posedge clk) disable iff (rst)
    (en && !start_ev && !stop_ev && state == S_ADDR && scl_rise && cnt == LAST
     && !gc_en && nxt == '0) |=> !ack_q);

  // R3: the acknowledge drive changes only while SCL is low
  a_r3_sda_edge_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_drive) && $past(en)) |-> !scl_s);
endmodule

// File: rtl/i2cs_recv.sv
module i2cs_recv import i2cs_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq_n
);
  localparam int AW = BYTE_W - 1;

  logic scl_s, sda_s;
  logic [AW-1:0] own_q;
  logic gc_q, ena_q, acken_q, sta_q, sto_q, flag, hold_q, irq_n_q;
  logic [7:0] status_q;
  logic [BYTE_W-1:0] data_q;
  logic ev_valid, ev_hold, flag_nxt;
  logic [7:0] ev_code;
  logic [BYTE_W-1:0] ev_data;

  wire ctrl_wr   = reg_wr && (reg_addr == 2'd1);
  wire clear_req = ctrl_wr && !reg_wdata[4];

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

  i2cs_rx_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst(rst), .en(ena_q && !sta_q && !sto_q), .ack_en(acken_q),
    .gc_en(gc_q), .own_addr(own_q), .scl_s(scl_s), .sda_s(sda_s),
    .sda_drive(sda_oe), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_data(ev_data), .ev_hold(ev_hold));

  always_comb begin
    flag_nxt = flag;
    if (clear_req) flag_nxt = 1'b0;
    if (ev_valid)  flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0; gc_q <= 1'b0; ena_q <= 1'b0; acken_q <= 1'b0;
      sta_q <= 1'b0; sto_q <= 1'b0; flag <= 1'b0; hold_q <= 1'b0;
      irq_n_q <= 1'b1; status_q <= ST_NONE; data_q <= '0; reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) begin
        own_q <= reg_wdata[BYTE_W-1:1];
        gc_q  <= reg_wdata[0];
      end
      if (ctrl_wr) begin
        ena_q <= reg_wdata[0]; acken_q <= reg_wdata[1];
        sta_q <= reg_wdata[2]; sto_q   <= reg_wdata[3];
      end
      if (ev_valid) begin
        hold_q   <= ev_hold;
        status_q <= ev_code;
        if (ev_code == ST_DAT_ACK || ev_code == ST_DAT_NACK) data_q <= ev_data;
      end
      flag    <= flag_nxt;
      irq_n_q <= !flag_nxt;
      case (reg_addr)
        2'd0:    reg_rdata <= {own_q, gc_q};
        2'd1:    reg_rdata <= BYTE_W'({flag, sto_q, sta_q, acken_q, ena_q});
        2'd2:    reg_rdata <= BYTE_W'(status_q);
        default: reg_rdata <= data_q;
      endcase
    end
  end

  assign scl_oe = flag && hold_q;
  assign irq_n  = irq_n_q;

  // R3: every bus event raises the interrupt
  a_r3_event_irq: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> !irq_n);

  // R10: the SCL hold lasts until the host clears the flag
  a_r10_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !clear_req) |=> scl_oe);

  // R10: a clearing write with no event releases the interrupt
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (clear_req && !ev_valid) |=> irq_n);

  // R9: an end-of-transfer event never stretches SCL
  a_r9_end_no_hold: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_code == ST_END) |=> !scl_oe);
endmodule

// File: tb/test_i2cs_recv.sv
`timescale 1ns/1ps
module test_i2cs_recv;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq_n;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  wire scl_w = !(m_scl_low || scl_oe);
  wire sda_w = !(m_sda_low || sda_oe);
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  i2cs_recv i_i2cs_recv (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_n(irq_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic bus_start;
    m_sda_low = 1'b1; tick(Q); m_scl_low = 1'b1; tick(Q);
  endtask

  task automatic bus_rstart;
    m_sda_low = 1'b0; tick(Q); m_scl_low = 1'b0; wait (scl_w); tick(Q);
    m_sda_low = 1'b1; tick(Q); m_scl_low = 1'b1; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; tick(Q); m_scl_low = 1'b0; wait (scl_w); tick(Q);
    m_sda_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; tick(Q);
      m_scl_low = 1'b0; wait (scl_w); tick(2*Q);
      m_scl_low = 1'b1; tick(Q);
    end
    m_sda_low = 1'b0; tick(Q);
    m_scl_low = 1'b0; wait (scl_w); tick(Q);
    ack = !sda_w; tick(Q);
    m_scl_low = 1'b1; tick(Q);
  endtask

  task automatic expect_event(input logic [7:0] code, input string tag);
    logic [7:0] st;
    check(irq_n == 1'b0, tag, irq_n, 0);
    hrd(2'd2, st);
    check(st == code, tag, st, code);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit ack, exp;
    tick(5); rst = 1'b0; tick(2);
    check(irq_n && !scl_oe && !sda_oe, "R1 outputs", {irq_n, scl_oe, sda_oe}, 3'b100);
    hrd(2'd2, rd); check(rd == 8'hF8, "R1 status", rd, 8'hF8);
    hrd(2'd0, rd); check(rd == 8'h00, "R1 addr", rd, 0);
    hrd(2'd1, rd); check(rd == 8'h00, "R1 ctrl", rd, 0);

    hwr(2'd0, {OWN, 1'b1});
    hrd(2'd0, rd); check(rd == {OWN, 1'b1}, "R2 addr readback", rd, {OWN, 1'b1});
    hwr(2'd1, 8'h03);
    hrd(2'd1, rd); check(rd == 8'h03, "R2 ctrl readback", rd, 8'h03);

    // address sweep with general call on: R3, R4, R5, R9, R10
    for (int a = 0; a < 128; a++) begin
      exp = (a == OWN) || (a == 0);
      bus_start;
      send_byte({a[6:0], 1'b0}, ack);
      check(ack == exp, (a == 0) ? "R5 gc ack" : (exp ? "R3 own ack" : "R4 other nack"), ack, exp);
      if (exp) begin
        check(scl_oe == 1'b1, "R10 hold", scl_oe, 1);
        expect_event((a == 0) ? 8'hD0 : 8'h60, (a == 0) ? "R5 status" : "R3 status");
        hwr(2'd1, 8'h03); tick(1);
        check(scl_oe == 1'b0, "R10 release", scl_oe, 0);
        bus_stop;
        check(scl_oe == 1'b0, "R9 stop no hold", scl_oe, 0);
        expect_event(8'hA0, "R9 stop status");
        hwr(2'd1, 8'h03);
      end else begin
        bus_stop;
        check(irq_n == 1'b1, "R4 ignored stop", irq_n, 1);
      end
    end

    // own address with read direction
    bus_start; send_byte({OWN, 1'b1}, ack);
    check(!ack, "R4 read dir nack", ack, 0);
    bus_stop; check(irq_n, "R4 read dir quiet", irq_n, 1);

    // general call disabled
    hwr(2'd0, {OWN, 1'b0});
    bus_start; send_byte(8'h00, ack);
    check(!ack, "R5 gc off nack", ack, 0);
    bus_stop; check(irq_n, "R5 gc off quiet", irq_n, 1);

    // data bytes
    bus_start; send_byte({OWN, 1'b0}, ack); hwr(2'd1, 8'h03);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b;
      b = 8'(k * 37 + 11);
      send_byte(b, ack);
      check(ack, "R6 data ack", ack, 1);
      expect_event(8'h80, "R6 status");
      hrd(2'd3, rd); check(rd == b, "R6 data reg", rd, b);
      hwr(2'd1, 8'h03);
    end
    bus_stop; expect_event(8'hA0, "R9 stop after data"); hwr(2'd1, 8'h03);

    // refusal of a data byte after ack-enable drops
    bus_start; send_byte({OWN, 1'b0}, ack); hwr(2'd1, 8'h03);
    send_byte(8'h3C, ack); check(ack, "R7 first byte ack", ack, 1);
    hwr(2'd1, 8'h01);
    send_byte(8'hC3, ack); check(!ack, "R7 nack", ack, 0);
    expect_event(8'h88, "R7 status");
    hrd(2'd3, rd); check(rd == 8'hC3, "R7 data reg", rd, 8'hC3);
    check(scl_oe, "R10 hold on nack", scl_oe, 1);
    hwr(2'd1, 8'h01);
    bus_stop; check(irq_n, "R7 unaddressed stop", irq_n, 1);

    // isolation and resume
    bus_start; send_byte({OWN, 1'b0}, ack);
    check(!ack, "R8 isolated nack", ack, 0);
    bus_stop; check(irq_n, "R8 isolated quiet", irq_n, 1);
    hwr(2'd1, 8'h03);
    bus_start; send_byte({OWN, 1'b0}, ack);
    check(ack, "R8 resumed ack", ack, 1);
    hwr(2'd1, 8'h03); bus_stop; hwr(2'd1, 8'h03);

    // repeated start
    bus_start; send_byte({OWN, 1'b0}, ack); hwr(2'd1, 8'h03);
    send_byte(8'h55, ack); hwr(2'd1, 8'h03);
    bus_rstart;
    check(!scl_oe, "R9 rstart no hold", scl_oe, 0);
    expect_event(8'hA0, "R9 rstart status"); hwr(2'd1, 8'h03);
    send_byte({OWN, 1'b0}, ack);
    check(ack, "R9 readdress ack", ack, 1);
    expect_event(8'h60, "R9 readdress status");
    hwr(2'd1, 8'h03); bus_stop; hwr(2'd1, 8'h03);

    // enable and request bits
    hwr(2'd1, 8'h02);
    bus_start; send_byte({OWN, 1'b0}, ack);
    check(!ack, "R11 disabled nack", ack, 0);
    bus_stop; check(irq_n, "R11 disabled quiet", irq_n, 1);
    hwr(2'd1, 8'h07);
    bus_start; send_byte({OWN, 1'b0}, ack);
    check(!ack, "R11 start req nack", ack, 0);
    bus_stop;
    hwr(2'd1, 8'h0B);
    bus_start; send_byte({OWN, 1'b0}, ack);
    check(!ack, "R11 stop req nack", ack, 0);
    bus_stop;

    // writing the flag bit as 1 does not set it
    hwr(2'd1, 8'h13); tick(2);
    check(irq_n, "R10 write one no set", irq_n, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule